// File: doc/BRIEF.md
# Priority Reference Selector with Reversion

This block chooses which of twelve timing references drives one clock generator. For each reference it receives a qualified flag, a count of how long that reference has been qualified, and a 4-bit rank taken from a programmable table. A rank of zero removes the reference from the choice. Among the other ranks, 1 is the strongest and 15 the weakest. The block returns the index of the chosen reference and a flag that says whether that index is usable.

In automatic mode the selector finds the best eligible reference. It orders references by rank first, then by qualified duration with the longer duration winning, then by the lower index. A revertive setting lets a better reference take over as soon as it becomes the best. A non-revertive setting keeps the current reference until it is lost. In manual mode a 4-bit index is passed straight through. The decision is registered, so the outputs follow the inputs one clock later.

Top module: `refsel_top`

## Requirements
- R1: A reference whose rank is 0 is never chosen in automatic mode, even when it is qualified. If such a reference is the active one, it counts as lost.
- R2: In automatic mode the eligible reference with the lowest nonzero rank value is chosen, because rank 1 is the strongest.
- R3: Among eligible references of equal rank, the one with the larger qualified-duration count is chosen.
- R4: Among eligible references with equal rank and equal duration, the lowest index is chosen.
- R5: With reversion enabled (revert_en=1), the output always follows the current best eligible reference.
- R6: With reversion disabled (revert_en=0), an active reference that is still qualified and has a nonzero rank is kept, even when a better reference exists.
- R7: When the active reference loses qualification, the best remaining eligible reference is chosen, in either reversion setting.
- R8: In automatic mode with no eligible reference, act_valid=0 and act_idx keeps its previous value.
- R9: In manual mode (auto_mode=0), a man_idx from 0 to 11 appears on act_idx with act_valid=1.
- R10: In manual mode, a man_idx of 12 or more drives act_valid=0 and act_idx keeps its previous value.
- R11: Outputs change only at a clock edge, one cycle after the inputs that cause the change.
- R12: Synchronous active-high reset gives act_idx=0 and act_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_qual | input | 12 | Qualified flag per reference, bit i for reference i |
| ref_prio | input | 48 | Rank per reference, bits [4i+3:4i] for reference i, 0 masks the reference |
| ref_dur | input | 192 | Qualified-duration count per reference, bits [16i+15:16i] |
| auto_mode | input | 1 | 1 selects automatically, 0 uses man_idx |
| revert_en | input | 1 | 1 revertive, 0 non-revertive |
| man_idx | input | 4 | Index used in manual mode |
| act_idx | output | 4 | Active reference index |
| act_valid | output | 1 | act_idx is usable |

## Verification
The automatic path is tried with four kinds of input:
- Ranks that differ, which separates rank ordering from index ordering.
- Equal ranks with different durations, which isolates the duration tiebreak.
- Equal ranks with equal durations, which leaves only the index order.
- A fully masked or fully unqualified table.

Reversion is tested by raising a stronger reference while a weaker one is active, once with each setting. The test then removes the active reference by dropping its qualification and, separately, by setting its rank to 0. Manual mode is driven with in-range indices and with 12 and 15 to show the invalid path and the held index.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    localparam int NUM_REFS = 12;
    localparam int PRIO_W   = 4;
    localparam int DUR_W    = 16;
    localparam int IDX_W    = $clog2(NUM_REFS);

    typedef struct packed {
        logic              ok;
        logic [PRIO_W-1:0] prio;
        logic [DUR_W-1:0]  dur;
        logic [IDX_W-1:0]  idx;
    } cand_t;

    typedef enum logic [1:0] {
        SEL_MANUAL,
        SEL_AUTO_REVERT,
        SEL_AUTO_HOLD
    } sel_mode_e;

    // true when candidate a ranks strictly ahead of candidate b
    function automatic logic outranks(cand_t a, cand_t b);
        if (!a.ok) return 1'b0;
        if (!b.ok) return 1'b1;
        if (a.prio != b.prio) return a.prio < b.prio;
        if (a.dur != b.dur) return a.dur > b.dur;
        return a.idx < b.idx;
    endfunction
endpackage

// File: rtl/refsel_cand.sv
module refsel_cand
    import refsel_pkg::*;
(
    input  logic [NUM_REFS-1:0]        qual,
    input  logic [NUM_REFS*PRIO_W-1:0] prio_flat,
    input  logic [NUM_REFS*DUR_W-1:0]  dur_flat,
    output cand_t                      cands [NUM_REFS],
    output logic [NUM_REFS-1:0]        elig
);
    for (genvar i = 0; i < NUM_REFS; i++) begin : g_cand
        logic [PRIO_W-1:0] p;
        assign p           = prio_flat[i*PRIO_W +: PRIO_W];
        assign elig[i]     = qual[i] && (p != '0);
        assign cands[i].ok   = elig[i];
        assign cands[i].prio = p;
        assign cands[i].dur  = dur_flat[i*DUR_W +: DUR_W];
        assign cands[i].idx  = IDX_W'(i);
    end
endmodule

// File: rtl/refsel_rank.sv
module refsel_rank
    import refsel_pkg::*;
(
    input  cand_t cands [NUM_REFS],
    output cand_t best
);
    cand_t chain [NUM_REFS];

    assign chain[0] = cands[0];
    for (genvar i = 1; i < NUM_REFS; i++) begin : g_chain
        assign chain[i] = outranks(cands[i], chain[i-1]) ? cands[i] : chain[i-1];
    end
    assign best = chain[NUM_REFS-1];
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               auto_mode,
    input  logic               revert_en,
    input  logic [IDX_W-1:0]   man_idx,
    input  cand_t              best,
    input  logic [NUM_REFS-1:0] elig,
    output logic [IDX_W-1:0]   act_idx,
    output logic               act_valid
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REFS - 1);

    sel_mode_e        mode;
    logic             cur_elig;
    logic             man_ok;
    logic [IDX_W-1:0] nxt_idx;
    logic             nxt_valid;

    assign mode   = !auto_mode ? SEL_MANUAL : (revert_en ? SEL_AUTO_REVERT : SEL_AUTO_HOLD);
    assign man_ok = man_idx <= LAST_IDX;

    always_comb begin
        cur_elig = 1'b0;
        for (int i = 0; i < NUM_REFS; i++) begin
            if (act_idx == IDX_W'(i)) cur_elig = elig[i];
        end
    end

    always_comb begin
        nxt_idx   = act_idx;
        nxt_valid = 1'b0;
        unique case (mode)
            SEL_MANUAL: begin
                if (man_ok) begin
                    nxt_idx   = man_idx;
                    nxt_valid = 1'b1;
                end
            end
            SEL_AUTO_REVERT: begin
                if (best.ok) begin
                    nxt_idx   = best.idx;
                    nxt_valid = 1'b1;
                end
            end
            SEL_AUTO_HOLD: begin
                if (act_valid && cur_elig) begin
                    nxt_valid = 1'b1;
                end else if (best.ok) begin
                    nxt_idx   = best.idx;
                    nxt_valid = 1'b1;
                end
            end
            default: nxt_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_idx   <= '0;
            act_valid <= 1'b0;
        end else begin
            act_idx   <= nxt_idx;
            act_valid <= nxt_valid;
        end
    end

    assert_none_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && !best.ok) |=> (!act_valid && act_idx == $past(act_idx)));

    assert_manual_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (!auto_mode && man_idx <= LAST_IDX) |=> (act_valid && act_idx == $past(man_idx)));

    assert_manual_bad_R10: assert property (@(posedge clk) disable iff (rst)
        (!auto_mode && man_idx > LAST_IDX) |=> (!act_valid && act_idx == $past(act_idx)));

    assert_revert_follow_R5: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && revert_en && best.ok) |=> (act_valid && act_idx == $past(best.idx)));

    assert_hold_active_R6: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && !revert_en && act_valid && cur_elig) |=> (act_valid && $stable(act_idx)));

    assert_loss_switch_R7: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && !cur_elig && best.ok) |=> (act_valid && act_idx == $past(best.idx)));
endmodule

// File: rtl/refsel_top.sv
module refsel_top
    import refsel_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_REFS-1:0]         ref_qual,
    input  logic [NUM_REFS*PRIO_W-1:0]  ref_prio,
    input  logic [NUM_REFS*DUR_W-1:0]   ref_dur,
    input  logic                        auto_mode,
    input  logic                        revert_en,
    input  logic [IDX_W-1:0]            man_idx,
    output logic [IDX_W-1:0]            act_idx,
    output logic                        act_valid
);
    cand_t               cands [NUM_REFS];
    cand_t               best;
    logic [NUM_REFS-1:0] elig;

    refsel_cand u_cand (
        .qual      (ref_qual),
        .prio_flat (ref_prio),
        .dur_flat  (ref_dur),
        .cands     (cands),
        .elig      (elig)
    );

    refsel_rank u_rank (
        .cands (cands),
        .best  (best)
    );

    refsel_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .auto_mode (auto_mode),
        .revert_en (revert_en),
        .man_idx   (man_idx),
        .best      (best),
        .elig      (elig),
        .act_idx   (act_idx),
        .act_valid (act_valid)
    );

    assert_mask_subset_R1: assert property (@(posedge clk) disable iff (rst)
        (elig & ~ref_qual) == '0);

    assert_best_exists_R2: assert property (@(posedge clk) disable iff (rst)
        best.ok == (elig != '0));

    assert_best_eligible_R1: assert property (@(posedge clk) disable iff (rst)
        best.ok |-> ref_prio[best.idx*PRIO_W +: PRIO_W] != '0);
endmodule

// File: tb/refsel_top_tb_top.sv
module refsel_top_tb_top;
    import refsel_pkg::*;

    typedef struct {
        logic [3:0] idx;
        logic       valid;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_REFS-1:0] ref_qual = '0;
    logic [NUM_REFS*PRIO_W-1:0] ref_prio;
    logic [NUM_REFS*DUR_W-1:0]  ref_dur;
    logic auto_mode = 1'b1;
    logic revert_en = 1'b1;
    logic [3:0] man_idx = '0;
    logic [3:0] act_idx;
    logic act_valid;

    logic [3:0]  prio [NUM_REFS];
    logic [15:0] dur  [NUM_REFS];

    exp_t sb [$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NUM_REFS; i++) begin
            ref_prio[i*PRIO_W +: PRIO_W] = prio[i];
            ref_dur[i*DUR_W +: DUR_W]    = dur[i];
        end
    end

    refsel_top dut_i (
        .clk(clk), .rst(rst), .ref_qual(ref_qual), .ref_prio(ref_prio),
        .ref_dur(ref_dur), .auto_mode(auto_mode), .revert_en(revert_en),
        .man_idx(man_idx), .act_idx(act_idx), .act_valid(act_valid)
    );

    task automatic step(input logic [3:0] ei, input logic ev, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.idx = ei; e.valid = ev; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compares registered outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (act_valid !== e.valid || (e.valid && act_idx !== e.idx) ||
                    (!e.valid && act_idx !== e.idx)) begin
                    fails++;
                    $display("FAIL %s: got idx=%0d valid=%0b, expected idx=%0d valid=%0b",
                             e.tag, act_idx, act_valid, e.idx, e.valid);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_REFS; i++) begin prio[i] = 4'd0; dur[i] = 16'd0; end
        @(negedge clk);
        step(4'd0, 1'b0, "R12 reset state");
        rst = 1'b0;
        ref_qual = '1;
        step(4'd0, 1'b0, "R1 R8 all ranks zero");
        prio[5] = 4'd3; prio[2] = 4'd7;
        step(4'd5, 1'b0 | 1'b1, "R2 lowest rank value wins");
        prio[7] = 4'd3; dur[7] = 16'd100; dur[5] = 16'd50;
        step(4'd7, 1'b1, "R3 R5 longer duration wins");
        dur[5] = 16'd100;
        step(4'd5, 1'b1, "R4 tie goes to lower index");
        revert_en = 1'b0; prio[9] = 4'd1;
        step(4'd5, 1'b1, "R6 non-revertive holds");
        ref_qual[5] = 1'b0;
        step(4'd9, 1'b1, "R7 loss picks best remaining");
        ref_qual[5] = 1'b1; dur[5] = 16'd200;
        step(4'd9, 1'b1, "R6 hold despite requalified ref");
        prio[9] = 4'd0;
        step(4'd5, 1'b1, "R1 R7 masked active counts as lost");
        ref_qual = '0;
        step(4'd5, 1'b0, "R8 nothing eligible holds index");
        auto_mode = 1'b0; man_idx = 4'd11;
        step(4'd11, 1'b1, "R9 manual index 11");
        man_idx = 4'd12;
        step(4'd11, 1'b0, "R10 manual index 12");
        man_idx = 4'd15;
        step(4'd11, 1'b0, "R10 manual index 15");
        man_idx = 4'd0;
        step(4'd0, 1'b1, "R9 manual index 0");
        auto_mode = 1'b1; revert_en = 1'b1; ref_qual = '1;
        step(4'd5, 1'b1, "R5 revertive picks best");
        // R11: inputs change mid-cycle, outputs must wait for the edge
        auto_mode = 1'b0; man_idx = 4'd3;
        #2;
        checks++;
        if (act_idx !== 4'd5 || act_valid !== 1'b1) begin
            fails++;
            $display("FAIL R11 early change: got idx=%0d valid=%0b, expected idx=5 valid=1",
                     act_idx, act_valid);
        end
        step(4'd3, 1'b1, "R11 R9 update after edge");
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule